// File: doc/BRIEF.md
# Page Request Group Tracker

This block sits in an endpoint next to its address-translation cache and handles translations that fail because the guest page is not resident. Each failing access arrives as a fault carrying the guest page number, the access direction and the ID of the DMA context that is stalled. The tracker places the fault in a page-request group and emits one page-request record per fault. Each record carries the page, the direction, the group index and a flag that marks the last page of the group. Every record is routed to the root. Packing the records into wire messages is left to a neighbouring block.

Faults join the currently open group until the source marks one as last or the group holds its maximum number of pages. The group is then closed and waits for an answer. One answer that names a waiting group releases all of its contexts in a single cycle, as a bit mask over context IDs. On success the contexts are told to retry translation. On any other code they are released with an error and must not retry. An answer that names a group which is not waiting is dropped and counted. A stop request closes the stream: it emits a stop marker, holds off new faults and signals completion once every group has been answered.

Top module: `prg_tracker`

## Requirements
- R1: After reset fault_ready is 1, preq_valid, rel_valid, stop_msg and flush_done are 0, and err_count is 0.
- R2: A fault accepted at a clock edge (fault_valid and fault_ready both 1) produces preq_valid=1 in the next cycle. That record carries the same page and write flag, the group index, and preq_route=3'b000 (to the root).
- R3: A fault joins the open group if one exists. Otherwise it opens the free group with the lowest index.
- R4: A group closes and starts waiting when a fault marked fault_last joins it, or when it reaches 4 pages. preq_last is 1 on the record of the closing fault and 0 on the others.
- R5: A response with rsp_code 2'b00 (success) naming a waiting group gives, in the next cycle, rel_valid=1, rel_retry=1 and rel_error=0. rel_mask has bit c set for every context c of that group. The group becomes free.
- R6: A response with rsp_code 2'b01 (invalid request), 2'b10 (response failure) or 2'b11 naming a waiting group releases the same mask with rel_error=1 and rel_retry=0. The group becomes free.
- R7: A response naming a group that is free or still open gives no release. It increments err_count by one in the next cycle, saturating at its maximum.
- R8: While all 8 groups are waiting, fault_ready is 0 and a presented fault produces no page-request record.
- R9: A stop request seen with no flush in progress gives stop_msg=1 for one cycle in the next cycle. It also closes any open group, and fault_ready stays 0 until the flush finishes.
- R10: flush_done pulses for one cycle, one cycle after the edge at which no group is open or waiting during a flush. That is two cycles after the stop request when nothing was outstanding. fault_ready returns to 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | A translation fault is presented |
| fault_ready | output | 1 | The tracker can accept a fault this cycle |
| fault_page | input | 52 | Guest page number of the fault |
| fault_write | input | 1 | 1 = write access requested, 0 = read |
| fault_ctx | input | 4 | ID of the stalled DMA context |
| fault_last | input | 1 | This fault closes its group |
| stop_req | input | 1 | Request to end the stream and drain all groups |
| rsp_valid | input | 1 | A page response is presented |
| rsp_group | input | 3 | Group index named by the response |
| rsp_code | input | 2 | 00 success, 01 invalid request, 10 response failure |
| preq_valid | output | 1 | Page-request record valid (one cycle) |
| preq_page | output | 52 | Guest page of the record |
| preq_write | output | 1 | Access direction of the record |
| preq_group | output | 3 | Group index of the record |
| preq_last | output | 1 | Record closes its group |
| preq_route | output | 3 | Routing code, 000 = to root |
| stop_msg | output | 1 | Stop marker to be sent (one cycle) |
| rel_valid | output | 1 | Context release valid (one cycle) |
| rel_mask | output | 16 | Released contexts, one bit per context ID |
| rel_retry | output | 1 | Released contexts retry translation |
| rel_error | output | 1 | Released contexts end with an error |
| flush_done | output | 1 | All groups answered after a stop (one cycle) |
| err_count | output | 8 | Sticky saturating count of dropped responses |

## Verification
Fault intake and response release can both act at the same clock edge. The fault goes to an open or free group, and the response frees a different group that is waiting. The bench provokes this by driving a fault into a freshly opened group and a success response for another waiting group in the same cycle. The scoreboard then expects both a page-request record with the right group and a release with the right mask in the following cycle. A stop request and the answer that completes the flush are also sequenced edge by edge, so the exact flush_done cycle is judged.

// File: rtl/prg_pkg.sv
package prg_pkg;

    typedef enum logic [1:0] {
        GRP_FREE = 2'd0,
        GRP_OPEN = 2'd1,
        GRP_WAIT = 2'd2
    } grp_st_e;

    localparam logic [1:0] RSP_SUCCESS  = 2'b00;
    localparam logic [1:0] RSP_INVALID  = 2'b01;
    localparam logic [1:0] RSP_FAILURE  = 2'b10;

    localparam logic [2:0] ROUTE_TO_ROOT = 3'b000;

endpackage

// File: rtl/prg_free_pick.sv
// Finds the lowest-index free group.
module prg_free_pick #(
    parameter int NUM_GROUPS = 8,
    localparam int GID_W = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:0] free_vec,
    output logic                  found,
    output logic [GID_W-1:0]      idx
);
    always_comb begin
        found = |free_vec;
        idx   = '0;
        for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (free_vec[i]) idx = GID_W'(i);
        end
    end
endmodule

// File: rtl/prg_ctx_merge.sv
// Builds a one-bit-per-context mask from the filled slots of one group.
module prg_ctx_merge #(
    parameter int PAGES_PER_GROUP = 4,
    parameter int CTX_W = 4,
    localparam int CNT_W = $clog2(PAGES_PER_GROUP + 1),
    localparam int NUM_CTX = 1 << CTX_W
) (
    input  logic [PAGES_PER_GROUP-1:0][CTX_W-1:0] ctx_list,
    input  logic [CNT_W-1:0]                      count,
    output logic [NUM_CTX-1:0]                    mask
);
    always_comb begin
        mask = '0;
        for (int i = 0; i < PAGES_PER_GROUP; i++) begin
            if (CNT_W'(i) < count) mask[ctx_list[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/prg_tracker.sv
module prg_tracker
    import prg_pkg::*;
#(
    parameter int NUM_GROUPS      = 8,
    parameter int PAGES_PER_GROUP = 4,
    parameter int PAGE_W          = 52,
    parameter int CTX_W           = 4,
    parameter int ERR_W           = 8,
    localparam int GID_W   = $clog2(NUM_GROUPS),
    localparam int CNT_W   = $clog2(PAGES_PER_GROUP + 1),
    localparam int NUM_CTX = 1 << CTX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_valid,
    output logic               fault_ready,
    input  logic [PAGE_W-1:0]  fault_page,
    input  logic               fault_write,
    input  logic [CTX_W-1:0]   fault_ctx,
    input  logic               fault_last,
    input  logic               stop_req,
    input  logic               rsp_valid,
    input  logic [GID_W-1:0]   rsp_group,
    input  logic [1:0]         rsp_code,
    output logic               preq_valid,
    output logic [PAGE_W-1:0]  preq_page,
    output logic               preq_write,
    output logic [GID_W-1:0]   preq_group,
    output logic               preq_last,
    output logic [2:0]         preq_route,
    output logic               stop_msg,
    output logic               rel_valid,
    output logic [NUM_CTX-1:0] rel_mask,
    output logic               rel_retry,
    output logic               rel_error,
    output logic               flush_done,
    output logic [ERR_W-1:0]   err_count
);

    typedef struct packed {
        grp_st_e [NUM_GROUPS-1:0]                                 st;
        logic [NUM_GROUPS-1:0][CNT_W-1:0]                         cnt;
        logic [NUM_GROUPS-1:0][PAGES_PER_GROUP-1:0][CTX_W-1:0]    ctx;
        logic                                                     open_v;
        logic [GID_W-1:0]                                         open_g;
        logic                                                     flush;
        logic                                                     preq_v;
        logic [PAGE_W-1:0]                                        preq_page;
        logic                                                     preq_write;
        logic [GID_W-1:0]                                         preq_group;
        logic                                                     preq_last;
        logic                                                     stop_msg;
        logic                                                     rel_v;
        logic [NUM_CTX-1:0]                                       rel_mask;
        logic                                                     rel_retry;
        logic                                                     rel_error;
        logic                                                     flush_done;
        logic [ERR_W-1:0]                                         err;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_GROUPS-1:0] free_vec;
    logic                  free_found;
    logic [GID_W-1:0]      free_idx;
    logic                  any_busy;
    logic [NUM_CTX-1:0]    rsp_mask;
    logic                  rsp_in_range;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_free
        assign free_vec[g] = (s_q.st[g] == GRP_FREE);
    end

    assign any_busy     = ~&free_vec;
    assign rsp_in_range = (int'(rsp_group) < NUM_GROUPS);

    prg_free_pick #(.NUM_GROUPS(NUM_GROUPS)) i_pick (
        .free_vec (free_vec),
        .found    (free_found),
        .idx      (free_idx)
    );

    prg_ctx_merge #(.PAGES_PER_GROUP(PAGES_PER_GROUP), .CTX_W(CTX_W)) i_merge (
        .ctx_list (s_q.ctx[rsp_group]),
        .count    (s_q.cnt[rsp_group]),
        .mask     (rsp_mask)
    );

    assign fault_ready = !s_q.flush && (s_q.open_v || free_found);

    always_comb begin
        logic [GID_W-1:0] g;
        logic [CNT_W-1:0] slot;
        logic             closing;

        s_d            = s_q;
        s_d.preq_v     = 1'b0;
        s_d.stop_msg   = 1'b0;
        s_d.rel_v      = 1'b0;
        s_d.rel_mask   = '0;
        s_d.rel_retry  = 1'b0;
        s_d.rel_error  = 1'b0;
        s_d.flush_done = 1'b0;
        g              = s_q.open_v ? s_q.open_g : free_idx;
        slot           = s_q.cnt[g];
        closing        = 1'b0;

        // fault intake: open group, else lowest free group
        if (fault_valid && fault_ready) begin
            closing           = fault_last || (slot + 1'b1 == CNT_W'(PAGES_PER_GROUP));
            s_d.ctx[g][slot[$clog2(PAGES_PER_GROUP)-1:0]] = fault_ctx;
            s_d.cnt[g]        = slot + 1'b1;
            s_d.st[g]         = closing ? GRP_WAIT : GRP_OPEN;
            s_d.open_v        = !closing;
            s_d.open_g        = g;
            s_d.preq_v        = 1'b1;
            s_d.preq_page     = fault_page;
            s_d.preq_write    = fault_write;
            s_d.preq_group    = g;
            s_d.preq_last     = closing;
        end

        // response: only waiting groups are outstanding
        if (rsp_valid) begin
            if (rsp_in_range && s_q.st[rsp_group] == GRP_WAIT) begin
                s_d.rel_v          = 1'b1;
                s_d.rel_mask       = rsp_mask;
                s_d.rel_retry      = (rsp_code == RSP_SUCCESS);
                s_d.rel_error      = (rsp_code != RSP_SUCCESS);
                s_d.st[rsp_group]  = GRP_FREE;
                s_d.cnt[rsp_group] = '0;
            end else if (s_q.err != '1) begin
                s_d.err = s_q.err + 1'b1;
            end
        end

        // stop marker: close the open group and start draining
        if (stop_req && !s_q.flush) begin
            s_d.stop_msg = 1'b1;
            s_d.flush    = 1'b1;
            if (s_d.open_v) begin
                s_d.st[s_d.open_g] = GRP_WAIT;
                s_d.open_v         = 1'b0;
            end
        end

        if (s_q.flush && !any_busy) begin
            s_d.flush_done = 1'b1;
            s_d.flush      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign preq_valid = s_q.preq_v;
    assign preq_page  = s_q.preq_page;
    assign preq_write = s_q.preq_write;
    assign preq_group = s_q.preq_group;
    assign preq_last  = s_q.preq_last;
    assign preq_route = ROUTE_TO_ROOT;
    assign stop_msg   = s_q.stop_msg;
    assign rel_valid  = s_q.rel_v;
    assign rel_mask   = s_q.rel_mask;
    assign rel_retry  = s_q.rel_retry;
    assign rel_error  = s_q.rel_error;
    assign flush_done = s_q.flush_done;
    assign err_count  = s_q.err;

endmodule

module prg_tracker_chk #(
    parameter int PAGE_W = 52,
    parameter int ERR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fault_valid,
    input logic              fault_ready,
    input logic [PAGE_W-1:0] fault_page,
    input logic              stop_req,
    input logic [1:0]        rsp_code,
    input logic              preq_valid,
    input logic [PAGE_W-1:0] preq_page,
    input logic              stop_msg,
    input logic              rel_valid,
    input logic              rel_retry,
    input logic              rel_error,
    input logic              flush_done,
    input logic [ERR_W-1:0]  err_count
);
    // R2
    preq_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid && fault_ready |=> preq_valid && preq_page == $past(fault_page));

    // R8
    no_accept_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_valid && fault_ready) |=> !preq_valid);

    // R5
    release_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (rel_retry != rel_error));

    // R6
    error_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && rel_error |-> $past(rsp_code) != 2'b00);

    // R9
    stop_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && fault_ready |=> stop_msg && !fault_ready);

    // R10
    flush_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> fault_ready);

    // R7
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_count != $past(err_count) |-> err_count == $past(err_count) + 1'b1);
endmodule

bind prg_tracker prg_tracker_chk #(.PAGE_W(PAGE_W), .ERR_W(ERR_W)) i_prg_tracker_chk (.*);

// File: tb/test_prg_tracker.sv
module test_prg_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic        fault_ready;
    logic [51:0] fault_page = '0;
    logic        fault_write = 1'b0;
    logic [3:0]  fault_ctx = '0;
    logic        fault_last = 1'b0;
    logic        stop_req = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_group = '0;
    logic [1:0]  rsp_code = '0;
    logic        preq_valid;
    logic [51:0] preq_page;
    logic        preq_write;
    logic [2:0]  preq_group;
    logic        preq_last;
    logic [2:0]  preq_route;
    logic        stop_msg;
    logic        rel_valid;
    logic [15:0] rel_mask;
    logic        rel_retry;
    logic        rel_error;
    logic        flush_done;
    logic [7:0]  err_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prg_tracker i_prg_tracker (.*);

    typedef struct packed {
        logic [51:0] page;
        logic        wr;
        logic [2:0]  grp;
        logic        last;
    } preq_t;

    typedef struct packed {
        logic [15:0] mask;
        logic        retry;
        logic        err;
    } rel_t;

    preq_t       exp_preq[$];
    rel_t        exp_rel[$];
    logic [15:0] gmask[8];
    int          exp_err = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare produced records against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (preq_valid) begin
                if (exp_preq.size() == 0) chk("R8 unexpected page request", 1, 0);
                else begin
                    preq_t e;
                    e = exp_preq.pop_front();
                    chk("R2 page", preq_page, e.page);
                    chk("R2 write", preq_write, e.wr);
                    chk("R3 group", preq_group, e.grp);
                    chk("R4 last", preq_last, e.last);
                    chk("R2 route", preq_route, 3'b000);
                end
            end
            if (rel_valid) begin
                if (exp_rel.size() == 0) chk("R7 unexpected release", 1, 0);
                else begin
                    rel_t e;
                    e = exp_rel.pop_front();
                    chk("R5 mask", rel_mask, e.mask);
                    chk("R5 retry", rel_retry, e.retry);
                    chk("R6 error", rel_error, e.err);
                end
            end
        end
    end

    task automatic set_fault(input logic [51:0] page, input logic wr, input logic [3:0] ctx,
                             input logic last, input int grp, input logic exp_last);
        preq_t e;
        chk("R8 ready for fault", fault_ready, 1);
        fault_valid = 1; fault_page = page; fault_write = wr; fault_ctx = ctx; fault_last = last;
        e.page = page; e.wr = wr; e.grp = 3'(grp); e.last = exp_last;
        exp_preq.push_back(e);
        gmask[grp][ctx] = 1'b1;
    endtask

    task automatic set_rsp(input int grp, input logic [1:0] code, input logic hit);
        rel_t e;
        rsp_valid = 1; rsp_group = 3'(grp); rsp_code = code;
        if (hit) begin
            e.mask = gmask[grp]; e.retry = (code == 2'b00); e.err = (code != 2'b00);
            exp_rel.push_back(e);
            gmask[grp] = '0;
        end else if (exp_err < 255) exp_err++;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        fault_valid = 0; fault_last = 0; rsp_valid = 0; stop_req = 0;
    endtask

    task automatic fault(input logic [51:0] page, input logic wr, input logic [3:0] ctx,
                         input logic last, input int grp, input logic exp_last);
        @(negedge clk);
        set_fault(page, wr, ctx, last, grp, exp_last);
        tick();
    endtask

    task automatic rsp(input int grp, input logic [1:0] code, input logic hit);
        @(negedge clk);
        set_rsp(grp, code, hit);
        tick();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) gmask[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fault_ready", fault_ready, 1);
        chk("R1 preq_valid", preq_valid, 0);
        chk("R1 rel_valid", rel_valid, 0);
        chk("R1 stop_msg", stop_msg, 0);
        chk("R1 flush_done", flush_done, 0);
        chk("R1 err_count", err_count, 0);

        // R3 R4 group 0 closed by last flag
        fault(52'h1001, 0, 4'd1, 0, 0, 0);
        fault(52'h1002, 1, 4'd2, 0, 0, 0);
        fault(52'h1003, 0, 4'd3, 1, 0, 1);
        // R4 group 1 closes on its 4th page
        fault(52'h2004, 1, 4'd4, 0, 1, 0);
        fault(52'h2005, 0, 4'd5, 0, 1, 0);
        fault(52'h2006, 1, 4'd6, 0, 1, 0);
        fault(52'h2007, 0, 4'd7, 0, 1, 1);
        // group 2 left open
        fault(52'h3008, 0, 4'd8, 0, 2, 0);

        // R7 responses to open and free groups are dropped
        rsp(2, 2'b00, 0);
        rsp(5, 2'b00, 0);
        @(negedge clk);
        chk("R7 err_count", err_count, 8'(exp_err));

        // R5 success, R6 invalid request
        rsp(0, 2'b00, 1);
        rsp(1, 2'b01, 1);

        // R3 joins open group 2, then lowest free is 0
        fault(52'h3009, 1, 4'd9, 1, 2, 1);
        fault(52'h400a, 0, 4'd10, 1, 0, 1);
        fault(52'h400b, 0, 4'd11, 1, 1, 1);
        fault(52'h400c, 1, 4'd12, 1, 3, 1);
        fault(52'h400d, 0, 4'd13, 1, 4, 1);
        fault(52'h400e, 0, 4'd14, 1, 5, 1);
        fault(52'h400f, 1, 4'd15, 1, 6, 1);
        fault(52'h4000, 0, 4'd0, 1, 7, 1);

        // R8 table full
        @(negedge clk);
        chk("R8 fault_ready when full", fault_ready, 0);
        fault_valid = 1; fault_page = 52'hdead; fault_last = 1;
        tick();
        @(negedge clk);
        chk("R8 no record when full", preq_valid, 0);

        // R6 response failure frees group 3
        rsp(3, 2'b10, 1);
        // fault into group 3 and success on group 4 at the same edge
        @(negedge clk);
        set_fault(52'h5003, 1, 4'd3, 0, 3, 0);
        set_rsp(4, 2'b00, 1);
        tick();
        // R6 code 11 treated as error
        rsp(5, 2'b11, 1);

        // R9 stop with groups 0,1,2,6,7 waiting and 3 open
        @(negedge clk);
        stop_req = 1;
        tick();
        @(negedge clk);
        chk("R9 stop_msg", stop_msg, 1);
        chk("R9 fault_ready during flush", fault_ready, 0);
        rsp(0, 2'b00, 1);
        rsp(1, 2'b00, 1);
        rsp(2, 2'b00, 1);
        rsp(6, 2'b10, 1);
        rsp(7, 2'b00, 1);
        @(negedge clk);
        chk("R10 no early flush_done", flush_done, 0);
        chk("R9 ready held low", fault_ready, 0);
        set_rsp(3, 2'b00, 1);  // R9: group 3 was closed by the stop
        tick();
        @(negedge clk);
        chk("R10 flush_done not yet", flush_done, 0);
        @(negedge clk);
        chk("R10 flush_done", flush_done, 1);
        chk("R10 ready restored", fault_ready, 1);

        // R10 stop with nothing outstanding
        @(negedge clk);
        stop_req = 1;
        tick();
        @(negedge clk);
        chk("R9 stop_msg empty", stop_msg, 1);
        chk("R10 flush_done delay", flush_done, 0);
        @(negedge clk);
        chk("R10 flush_done empty", flush_done, 1);

        @(negedge clk);
        chk("R7 err_count final", err_count, 8'(exp_err));
        chk("R2 queue drained", exp_preq.size(), 0);
        chk("R5 queue drained", exp_rel.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule